// File: doc/BRIEF.md
# Masked Level Interrupt Priority Controller

This block gathers a set of level-sensitive interrupt requests, gates them with an enable mask that software owns, and raises one combined interrupt line toward the processor whenever an enabled request is active. Software finds which source to service by reading a vector register. The vector names the lowest-numbered active and enabled source, so lower indices always win.

There is no per-source acknowledge. A source stops being pending when its request line drops, and the block follows that level on every clock. Software reaches the block through a small 16-bit register port with two registers. Offset 0x00 is the read-only vector. Offset 0x02 is the read/write enable mask. The port is a plain single-cycle strobe interface with no back-pressure: a write is taken on the clock edge where `wr_en` is high, and read data is presented in the same cycle that `rd_en` is high.

Top module: `lvl_irq_prio`

## Requirements
- R1: Each pending bit follows its request level. Bit i is set one clock after `irq_in[i]` is high while mask bit i is 1. It is cleared one clock after `irq_in[i]` goes low.
- R2: `irq_out` is registered. It equals the OR of (request levels AND effective mask) from the previous clock, so a change at the inputs is not visible on `irq_out` before the next rising edge.
- R3: A read at byte offset 0x00 returns ((k+1) << 2), where k is the lowest index whose pending bit is set. It returns 0 when nothing is pending. The result is computed from the same registered pending state that drives `irq_out`.
- R4: A write at byte offset 0x02 loads the mask from `wdata[15:0]`, where bit i enables source i. A read at offset 0x02 returns the mask. The new mask gates the requests sampled on the very edge that takes the write, so `irq_out` and the vector reflect it one clock later.
- R5: A write to any offset other than 0x02 (including 0x00 and odd offsets) changes nothing. A read at any offset other than 0x00 and 0x02 returns 0.
- R6: After reset the mask is 0x0010 (only source 4 enabled), nothing is pending, the vector reads 0 and `irq_out` is low.
- R7: `rdata` is 0 in any cycle where `rd_en` is low.
- R8: Reading the vector register has no side effect. Repeated reads return the same value and leave the mask and `irq_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Level request lines, bit i is source i |
| rd_en | input | 1 | Read strobe for the register port |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle `rd_en` is high |
| irq_out | output | 1 | Combined interrupt, high while any enabled source is pending |

## Verification
The properties assume the following about the inputs:
- `irq_in` is already synchronous to `clk`.
- The register strobes and the address are stable around each rising edge.
- Offsets are compared exactly, so a read or write touches at most one register per cycle.

The stimulus changes every input on the falling edge and samples results in the low phase just before the next rising edge. A request change therefore always lands one whole cycle before its effect is checked. Sweeps cover every single source, a few hundred mixed request and mask patterns, and every even and odd offset in a small window.

// File: rtl/icu_pkg.sv
package icu_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_VEC  = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/icu_reg_decode.sv
module icu_reg_decode
  import icu_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int VEC_OFF  = 0,
  parameter int MASK_OFF = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  localparam logic [ADDR_W-1:0] VecAddr  = ADDR_W'(VEC_OFF);
  localparam logic [ADDR_W-1:0] MaskAddr = ADDR_W'(MASK_OFF);

  always_comb begin
    if (addr_i == VecAddr)       sel_o = SEL_VEC;
    else if (addr_i == MaskAddr) sel_o = SEL_MASK;
    else                         sel_o = SEL_NONE;
  end

endmodule

// File: rtl/icu_mask_reg.sv
module icu_mask_reg #(
  parameter int                   NUM_SRC  = 16,
  parameter logic [NUM_SRC-1:0]   MASK_RST = NUM_SRC'(16'h0010)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [NUM_SRC-1:0] load_val_i,
  output logic [NUM_SRC-1:0] mask_q_o,
  output logic [NUM_SRC-1:0] mask_nxt_o
);

  always_comb begin
    mask_nxt_o = load_i ? load_val_i : mask_q_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q_o <= MASK_RST;
    else        mask_q_o <= mask_nxt_o;
  end

endmodule

// File: rtl/icu_pend_stage.sv
module icu_pend_stage #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] pend_q_o,
  output logic               any_q_o
);

  logic [NUM_SRC-1:0] gated;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign gated[g] = req_i[g] & mask_i[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q_o[g] <= 1'b0;
      else        pend_q_o[g] <= gated[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) any_q_o <= 1'b0;
    else        any_q_o <= |gated;
  end

endmodule

// File: rtl/icu_prio_enc.sv
module icu_prio_enc #(
  parameter int NUM_SRC    = 16,
  parameter int DATA_W     = 16,
  parameter bit ISOLATE_LO = 1'b1
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [DATA_W-1:0]  vec_o
);

  localparam int IdxW = $clog2(NUM_SRC + 1);

  if (ISOLATE_LO) begin : g_iso
    logic [NUM_SRC-1:0] lowest;
    logic [IdxW-1:0]    num;
    assign lowest = pend_i & (~pend_i + NUM_SRC'(1));
    always_comb begin
      num = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (lowest[i]) num = num | IdxW'(i + 1);
      end
      vec_o = DATA_W'(num) << 2;
    end
  end else begin : g_scan
    always_comb begin
      vec_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (pend_i[i]) vec_o = DATA_W'((i + 1) * 4);
      end
    end
  end

endmodule

// File: rtl/lvl_irq_prio.sv
module lvl_irq_prio
  import icu_pkg::*;
#(
  parameter int                 NUM_SRC    = 16,
  parameter int                 DATA_W     = 16,
  parameter int                 ADDR_W     = 12,
  parameter int                 VEC_OFF    = 0,
  parameter int                 MASK_OFF   = 2,
  parameter logic [NUM_SRC-1:0] MASK_RST   = NUM_SRC'(16'h0010),
  parameter bit                 ISOLATE_LO = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_out
);

  reg_sel_e           sel;
  logic               mask_ld;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_nxt;
  logic [NUM_SRC-1:0] pend_q;
  logic [DATA_W-1:0]  vec;

  icu_reg_decode #(
    .ADDR_W(ADDR_W), .VEC_OFF(VEC_OFF), .MASK_OFF(MASK_OFF)
  ) u_dec (
    .addr_i(addr),
    .sel_o (sel)
  );

  assign mask_ld = wr_en && (sel == SEL_MASK);

  icu_mask_reg #(
    .NUM_SRC(NUM_SRC), .MASK_RST(MASK_RST)
  ) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (mask_ld),
    .load_val_i(wdata[NUM_SRC-1:0]),
    .mask_q_o  (mask_q),
    .mask_nxt_o(mask_nxt)
  );

  icu_pend_stage #(
    .NUM_SRC(NUM_SRC)
  ) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (irq_in),
    .mask_i  (mask_nxt),
    .pend_q_o(pend_q),
    .any_q_o (irq_out)
  );

  icu_prio_enc #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ISOLATE_LO(ISOLATE_LO)
  ) u_enc (
    .pend_i(pend_q),
    .vec_o (vec)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_VEC:  rdata = vec;
        SEL_MASK: rdata = DATA_W'(mask_q);
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/lvl_irq_prio_chk.sv
module lvl_irq_prio_chk #(
  parameter int NUM_SRC  = 16,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 12,
  parameter int VEC_OFF  = 0,
  parameter int MASK_OFF = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_in,
  input logic               rd_en,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rdata,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] mask_q
);

  localparam logic [ADDR_W-1:0] VA = ADDR_W'(VEC_OFF);
  localparam logic [ADDR_W-1:0] MA = ADDR_W'(MASK_OFF);
  localparam logic [DATA_W-1:0] VMAX = DATA_W'(NUM_SRC * 4);

  AST_OUT_TRACKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == MA) |=> irq_out == |($past(irq_in) & $past(mask_q))); // R2

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == MA) |=> mask_q == $past(wdata[NUM_SRC-1:0])); // R4

  AST_MASK_OTHER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == MA) |=> $stable(mask_q)); // R5

  AST_VEC_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == VA) |-> ((rdata == '0) == !irq_out)); // R3

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == VA && irq_out) |->
      (rdata[1:0] == 2'b00 && rdata >= DATA_W'(4) && rdata <= VMAX)); // R3

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0); // R7

  AST_OTHER_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != VA && addr != MA) |-> rdata == '0); // R5

endmodule

bind lvl_irq_prio lvl_irq_prio_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .VEC_OFF(VEC_OFF), .MASK_OFF(MASK_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .mask_q(mask_q)
);

// File: tb/lvl_irq_prio_tb.sv
module lvl_irq_prio_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_out;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lvl_irq_prio u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  function automatic logic [15:0] exp_vec(input logic [15:0] p);
    logic [15:0] v = '0;
    for (int i = 15; i >= 0; i--) if (p[i]) v = 16'((i + 1) << 2);
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic set_in(input logic [15:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [15:0] d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6 reset state
    rd(12'h000, d); chk("R6 vector after reset", d, 16'h0);
    rd(12'h002, d); chk("R6 mask after reset", d, 16'h0010);
    chk("R6 irq_out after reset", irq_out, 0);

    // R1 with reset mask: only source 4 enabled
    set_in(16'h0008);
    chk("R1 masked source 3 gives no irq", irq_out, 0);
    rd(12'h000, d); chk("R1 masked source 3 vector", d, 0);
    set_in(16'h0010);
    chk("R1 source 4 raises irq", irq_out, 1);
    rd(12'h000, d); chk("R3 source 4 vector", d, 16'd20);
    set_in(16'h0000);
    chk("R1 source 4 drop clears irq", irq_out, 0);

    // R2 registered output
    @(negedge clk); irq_in = 16'h0010;
    #1 chk("R2 irq_out not yet changed", irq_out, 0);
    @(negedge clk); chk("R2 irq_out after one edge", irq_out, 1);
    set_in(16'h0000);

    // R4 mask write and readback
    wr(12'h002, 16'hFFFF);
    rd(12'h002, d); chk("R4 mask readback", d, 16'hFFFF);

    // R3 R1 single source sweep
    for (int k = 0; k < 16; k++) begin
      set_in(16'(1 << k));
      chk($sformatf("R1 single source %0d irq", k), irq_out, 1);
      rd(12'h000, d); chk($sformatf("R3 single source %0d vector", k), d, 16'((k + 1) * 4));
      set_in(16'h0000);
      chk($sformatf("R1 source %0d drop", k), irq_out, 0);
    end

    // R3 R2 mixed pattern sweep
    for (int i = 0; i < 320; i++) begin
      logic [15:0] p, m;
      p = 16'((i * 40503) ^ (i << 7));
      m = 16'((i * 9973) + 16'h1234);
      if (i % 7 == 0) p = '0;
      wr(12'h002, m);
      set_in(p);
      chk($sformatf("R2 pattern %0d irq", i), irq_out, |(p & m));
      rd(12'h000, d); chk($sformatf("R3 pattern %0d vector", i), d, exp_vec(p & m));
    end

    // R4 mask write takes effect on the next edge
    wr(12'h002, 16'h0000);
    set_in(16'hFFFF);
    chk("R4 all masked irq low", irq_out, 0);
    @(negedge clk); addr = 12'h002; wdata = 16'h0200; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = '0;
    chk("R4 new mask visible on irq_out", irq_out, 1);
    rd(12'h000, d); chk("R4 new mask visible on vector", d, 16'd40);

    // R5 other offsets
    for (int o = 1; o < 40; o++) begin
      if (o == 2) continue;
      wr(12'(o), 16'h5A5A);
      rd(12'h002, d); chk($sformatf("R5 write at 0x%0h ignored", o), d, 16'h0200);
      if (o != 0) begin
        rd(12'(o), d); chk($sformatf("R5 read at 0x%0h is zero", o), d, 0);
      end
    end
    wr(12'h000, 16'hFFFF);
    rd(12'h002, d); chk("R5 write at vector offset ignored", d, 16'h0200);
    rd(12'h000, d); chk("R5 vector unchanged after write", d, 16'd40);
    wr(12'hFFE, 16'hFFFF);
    rd(12'h002, d); chk("R5 high offset write ignored", d, 16'h0200);

    // R7 rdata idle
    @(negedge clk); addr = 12'h002; rd_en = 1'b0;
    #1 chk("R7 rdata zero without rd_en", rdata, 0);
    addr = '0;

    // R8 vector reads have no side effect
    rd(12'h000, d);
    for (int r = 0; r < 6; r++) begin
      rd(12'h000, d2); chk($sformatf("R8 repeated vector read %0d", r), d2, d);
    end
    rd(12'h002, d); chk("R8 mask unchanged by reads", d, 16'h0200);
    chk("R8 irq unchanged by reads", irq_out, 1);

    // R6 reset in mid-operation
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); irq_in = '0; rst_n = 1'b1;
    rd(12'h002, d); chk("R6 mask after second reset", d, 16'h0010);
    chk("R6 irq after second reset", irq_out, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule